// File: doc/BRIEF.md
# Compressed Instruction Expander (RV32)

This combinational block takes one 16-bit compressed RISC-V halfword and produces the equivalent 32-bit RV32I instruction word. A decode stage places it between the fetch buffer and the main decoder, so that the rest of the pipeline only ever sees full-width instructions. The block covers only the base integer compressed subset. Encodings that belong to the floating-point compressed loads and stores, to the other compressed subsets or to 64-bit-only forms are reported as illegal.

Three pieces sit below the top. A package holds the immediate reassembly and the RV32I field packing as functions. An unpack module reassembles every scrambled immediate in parallel. A decoder picks the expansion and judges whether the encoding is legal. The top passes 32-bit instructions (low bits `11`) through, and it masks the output of illegal encodings to zero.

Top module: `rvc_expander`

## Requirements
- R1: When `halfword_i[1:0]` is `11`, `compressed_o` is 0, `illegal_o` is 0 and `instr_o` is `{16'h0000, halfword_i}`. Every other halfword gives `compressed_o`=1, and any legal expansion has `instr_o[1:0]`=`11`.
- R2: In quadrant `00`, function `010` is LW and function `110` is SW, with word offset {b5,b12:10,b6,00}. The base register comes from b9:7 and the data register from b4:2, and each 3-bit field names x8+field.
- R3: In quadrant `00`, function `000` is ADDI rd'=x2+nzuimm with nzuimm={b10:7,b12:11,b5,b6,00}. A zero nzuimm is illegal, and this includes the all-zero halfword.
- R4: Quadrant `01` functions `001` and `101` give JAL with rd=x1 and rd=x0 respectively. The offset is {b12,b8,b10:9,b6,b7,b2,b11,b5:3,0}, sign-extended from bit 11.
- R5: Quadrant `01` functions `110` and `111` give BEQ and BNE of x8+b9:7 against x0. The offset is {b12,b6:5,b2,b11:10,b4:3,0}, sign-extended from bit 8.
- R6: Quadrant `01` function `011` with rd (b11:7) = 2 gives ADDI x2,x2,imm, where imm={b12,b4:3,b5,b2,b6,0000} is sign-extended from bit 9. Any other rd gives LUI rd with upper immediate {b12,b6:2} sign-extended. A zero immediate is illegal in both forms, and LUI with rd=x0 is illegal.
- R7: SRLI, SRAI (quadrant `01`, function `100`, b11:10=`00`/`01`) and SLLI (quadrant `10`, function `000`) take the shift amount from b6:2. They are illegal when b12=1. A zero shift amount still expands.
- R8: Quadrant `01`, function `100`, b11:10=`10` is ANDI with a sign-extended {b12,b6:2}. With b11:10=`11`, b12=1 is illegal; otherwise b6:5 = 00/01/10/11 selects SUB/XOR/OR/AND of rd' and x8+b4:2.
- R9: Quadrant `10`, function `100`: b12=0 with rs2=0 gives JALR x0,0(rs1), illegal for rs1=x0; b12=0 with rs2≠0 gives ADD rd,x0,rs2. b12=1 with rs2=0 and rs1=0 gives EBREAK (`32'h00100073`); b12=1 with rs2=0 and rs1≠0 gives JALR x1,0(rs1); b12=1 with rs2≠0 gives ADD rd,rd,rs2.
- R10: Quadrant `10` function `010` gives LW rd,{b3:2,b12,b6:4,00}(x2), illegal for rd=x0. Function `110` gives SW rs2,{b8:7,b12:9,00}(x2).
- R11: The unused slots are illegal: quadrant `00` functions 001, 011, 100, 101 and 111, and quadrant `10` functions 001, 011, 101 and 111.
- R12: `instr_o` is all zeros for any illegal compressed halfword. `illegal_o` is raised only while `valid_i` is high. `valid_o` follows `valid_i`.
- R13: The hint forms still expand and do not trap. Quadrant `01` function `000` gives ADDI rd,rd,imm (all-zero fields give the no-op `32'h00000013`). Function `010` gives ADDI rd,x0,imm. Writes to x0 in shifts, moves and adds expand as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| halfword_i | input | 16 | Instruction halfword to expand |
| valid_i | input | 1 | Halfword qualifier |
| instr_o | output | 32 | Expanded or passed-through instruction |
| valid_o | output | 1 | Result qualifier |
| illegal_o | output | 1 | Reserved or unsupported compressed encoding |
| compressed_o | output | 1 | Low when the low two bits are `11` |

## Verification
The block has no tunable parameters: the instruction set fixes its widths, so the bench uses the only configuration. Because the input space has just 65536 points, the bench sweeps every halfword against an independent bit-level reference model. This covers every scrambled immediate bit, every short-register value and every reserved slot exactly. Hard-coded golden words for the no-op, load-immediate and breakpoint encodings, plus vectors driven with the qualifier low, add a check of the model itself and of the valid gating.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int HW = 16;
  localparam int WW = 32;
  localparam int RW = 5;
  typedef logic [HW-1:0] half_t;
  typedef logic [WW-1:0] word_t;
  typedef logic [RW-1:0] reg_t;

  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_IMM   = 7'b0010011;
  localparam logic [6:0] OP_REG   = 7'b0110011;
  localparam logic [6:0] OP_LUI   = 7'b0110111;
  localparam logic [6:0] OP_BR    = 7'b1100011;
  localparam logic [6:0] OP_JAL   = 7'b1101111;
  localparam logic [6:0] OP_JALR  = 7'b1100111;
  localparam logic [6:0] OP_SYS   = 7'b1110011;
  localparam reg_t R_ZERO = 5'd0;
  localparam reg_t R_LINK = 5'd1;
  localparam reg_t R_SP   = 5'd2;

  typedef struct packed {
    logic [20:0] jmp;
    logic [12:0] br;
    logic [11:0] ci;
    logic [11:0] sp16;
    logic [19:0] lui;
    logic [11:0] ciw;
    logic [11:0] wofs;
    logic [11:0] lwsp;
    logic [11:0] swsp;
  } imm_set_t;

  // 3-bit short register field selects x8..x15
  function automatic reg_t short_reg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [20:0] imm_jump(input half_t h);
    return {{9{h[12]}}, h[12], h[8], h[10:9], h[6], h[7], h[2], h[11], h[5:3], 1'b0};
  endfunction
  function automatic logic [12:0] imm_branch(input half_t h);
    return {{4{h[12]}}, h[12], h[6:5], h[2], h[11:10], h[4:3], 1'b0};
  endfunction
  function automatic logic [11:0] imm_six(input half_t h);
    return {{6{h[12]}}, h[12], h[6:2]};
  endfunction
  function automatic logic [11:0] imm_stack_adj(input half_t h);
    return {{2{h[12]}}, h[12], h[4:3], h[5], h[2], h[6], 4'b0000};
  endfunction
  function automatic logic [19:0] imm_upper(input half_t h);
    return {{14{h[12]}}, h[12], h[6:2]};
  endfunction
  function automatic logic [11:0] imm_sp_addr(input half_t h);
    return {2'b00, h[10:7], h[12:11], h[5], h[6], 2'b00};
  endfunction
  function automatic logic [11:0] imm_word(input half_t h);
    return {5'b00000, h[5], h[12:10], h[6], 2'b00};
  endfunction
  function automatic logic [11:0] imm_sp_load(input half_t h);
    return {4'b0000, h[3:2], h[12], h[6:4], 2'b00};
  endfunction
  function automatic logic [11:0] imm_sp_store(input half_t h);
    return {4'b0000, h[8:7], h[12:9], 2'b00};
  endfunction

  function automatic word_t pack_i(input logic [11:0] imm, input reg_t rs1,
                                   input logic [2:0] f3, input reg_t rd, input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic word_t pack_r(input logic [6:0] f7, input reg_t rs2, input reg_t rs1,
                                   input logic [2:0] f3, input reg_t rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction
  function automatic word_t pack_s(input logic [11:0] imm, input reg_t rs2, input reg_t rs1,
                                   input logic [2:0] f3, input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction
  function automatic word_t pack_b(input logic [12:0] imm, input reg_t rs2, input reg_t rs1,
                                   input logic [2:0] f3, input logic [6:0] op);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], op};
  endfunction
  function automatic word_t pack_j(input logic [20:0] imm, input reg_t rd, input logic [6:0] op);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, op};
  endfunction
  function automatic word_t pack_u(input logic [19:0] imm, input reg_t rd, input logic [6:0] op);
    return {imm, rd, op};
  endfunction
endpackage

// File: rtl/rvc_imm_unpack.sv
module rvc_imm_unpack
  import rvc_pkg::*;
(
  input  half_t    half_i,
  output imm_set_t imm_o
);
  always_comb begin
    imm_o.jmp  = imm_jump(half_i);
    imm_o.br   = imm_branch(half_i);
    imm_o.ci   = imm_six(half_i);
    imm_o.sp16 = imm_stack_adj(half_i);
    imm_o.lui  = imm_upper(half_i);
    imm_o.ciw  = imm_sp_addr(half_i);
    imm_o.wofs = imm_word(half_i);
    imm_o.lwsp = imm_sp_load(half_i);
    imm_o.swsp = imm_sp_store(half_i);
  end
endmodule

// File: rtl/rvc_decode.sv
module rvc_decode
  import rvc_pkg::*;
(
  input  half_t    half_i,
  input  imm_set_t imm_i,
  output word_t    word_o,
  output logic     bad_o
);
  logic [1:0] quad;
  logic [2:0] fn;
  logic       b12;
  reg_t       rd_full, rs2_full, rd_short, rs2_short;
  logic [2:0] alu_f3;

  assign quad      = half_i[1:0];
  assign fn        = half_i[15:13];
  assign b12       = half_i[12];
  assign rd_full   = half_i[11:7];
  assign rs2_full  = half_i[6:2];
  assign rd_short  = short_reg(half_i[9:7]);
  assign rs2_short = short_reg(half_i[4:2]);

  always_comb begin
    case (half_i[6:5])
      2'b00:   alu_f3 = 3'b000;
      2'b01:   alu_f3 = 3'b100;
      2'b10:   alu_f3 = 3'b110;
      default: alu_f3 = 3'b111;
    endcase
  end

  always_comb begin
    word_o = '0;
    bad_o  = 1'b0;
    case ({quad, fn})
      5'b00_000: begin
        bad_o  = (imm_i.ciw == 12'd0);
        word_o = pack_i(imm_i.ciw, R_SP, 3'b000, rs2_short, OP_IMM);
      end
      5'b00_010: word_o = pack_i(imm_i.wofs, rd_short, 3'b010, rs2_short, OP_LOAD);
      5'b00_110: word_o = pack_s(imm_i.wofs, rs2_short, rd_short, 3'b010, OP_STORE);
      5'b01_000: word_o = pack_i(imm_i.ci, rd_full, 3'b000, rd_full, OP_IMM);
      5'b01_001: word_o = pack_j(imm_i.jmp, R_LINK, OP_JAL);
      5'b01_010: word_o = pack_i(imm_i.ci, R_ZERO, 3'b000, rd_full, OP_IMM);
      5'b01_011: begin
        if (rd_full == R_SP) begin
          bad_o  = (imm_i.sp16 == 12'd0);
          word_o = pack_i(imm_i.sp16, R_SP, 3'b000, R_SP, OP_IMM);
        end else begin
          bad_o  = (rd_full == R_ZERO) || (imm_i.lui == 20'd0);
          word_o = pack_u(imm_i.lui, rd_full, OP_LUI);
        end
      end
      5'b01_100: begin
        case (half_i[11:10])
          2'b00: begin
            bad_o  = b12;
            word_o = pack_i({7'b0000000, rs2_full}, rd_short, 3'b101, rd_short, OP_IMM);
          end
          2'b01: begin
            bad_o  = b12;
            word_o = pack_i({7'b0100000, rs2_full}, rd_short, 3'b101, rd_short, OP_IMM);
          end
          2'b10: word_o = pack_i(imm_i.ci, rd_short, 3'b111, rd_short, OP_IMM);
          default: begin
            bad_o  = b12;
            word_o = pack_r((half_i[6:5] == 2'b00) ? 7'b0100000 : 7'b0000000,
                            rs2_short, rd_short, alu_f3, rd_short, OP_REG);
          end
        endcase
      end
      5'b01_101: word_o = pack_j(imm_i.jmp, R_ZERO, OP_JAL);
      5'b01_110: word_o = pack_b(imm_i.br, R_ZERO, rd_short, 3'b000, OP_BR);
      5'b01_111: word_o = pack_b(imm_i.br, R_ZERO, rd_short, 3'b001, OP_BR);
      5'b10_000: begin
        bad_o  = b12;
        word_o = pack_i({7'b0000000, rs2_full}, rd_full, 3'b001, rd_full, OP_IMM);
      end
      5'b10_010: begin
        bad_o  = (rd_full == R_ZERO);
        word_o = pack_i(imm_i.lwsp, R_SP, 3'b010, rd_full, OP_LOAD);
      end
      5'b10_100: begin
        if (!b12) begin
          if (rs2_full == R_ZERO) begin
            bad_o  = (rd_full == R_ZERO);
            word_o = pack_i(12'd0, rd_full, 3'b000, R_ZERO, OP_JALR);
          end else begin
            word_o = pack_r(7'd0, rs2_full, R_ZERO, 3'b000, rd_full, OP_REG);
          end
        end else if (rs2_full == R_ZERO) begin
          if (rd_full == R_ZERO) word_o = pack_i(12'd1, R_ZERO, 3'b000, R_ZERO, OP_SYS);
          else                   word_o = pack_i(12'd0, rd_full, 3'b000, R_LINK, OP_JALR);
        end else begin
          word_o = pack_r(7'd0, rs2_full, rd_full, 3'b000, rd_full, OP_REG);
        end
      end
      5'b10_110: word_o = pack_s(imm_i.swsp, rs2_full, R_SP, 3'b010, OP_STORE);
      default: bad_o = 1'b1;
    endcase
  end

  always_comb begin
    if (quad == 2'b01 && fn == 3'b100 && !half_i[11] && b12)
      p_shift_wide_r7: assert (bad_o) else $error("shift with bit 12 not flagged");
    if (quad == 2'b10 && fn == 3'b000 && b12)
      p_left_shift_wide_r7: assert (bad_o) else $error("left shift with bit 12 not flagged");
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_pkg::*;
(
  input  logic [15:0] halfword_i,
  input  logic        valid_i,
  output logic [31:0] instr_o,
  output logic        valid_o,
  output logic        illegal_o,
  output logic        compressed_o
);
  imm_set_t imm_set;
  word_t    dec_word;
  logic     dec_bad;
  logic     is_short;

  rvc_imm_unpack u_unpack (
    .half_i (halfword_i),
    .imm_o  (imm_set)
  );

  rvc_decode u_decode (
    .half_i (halfword_i),
    .imm_i  (imm_set),
    .word_o (dec_word),
    .bad_o  (dec_bad)
  );

  assign is_short     = (halfword_i[1:0] != 2'b11);
  assign compressed_o = is_short;
  assign valid_o      = valid_i;
  assign illegal_o    = valid_i && is_short && dec_bad;

  always_comb begin
    if (!is_short)    instr_o = {16'h0000, halfword_i};
    else if (dec_bad) instr_o = '0;
    else              instr_o = dec_word;
  end

  always_comb begin
    if (!compressed_o)
      p_pass_through_r1: assert (!illegal_o && instr_o == {16'h0000, halfword_i})
        else $error("wide instruction altered");
    if (compressed_o && !dec_bad)
      p_full_form_r1: assert (dec_word[1:0] == 2'b11) else $error("expansion lacks wide opcode");
    if (valid_i && halfword_i == 16'h0000)
      p_zero_halfword_r3: assert (illegal_o) else $error("all-zero halfword accepted");
    if (halfword_i == 16'h9002)
      p_breakpoint_r9: assert (instr_o == 32'h00100073) else $error("breakpoint misexpanded");
    if (illegal_o)
      p_illegal_zero_r12: assert (instr_o == 32'd0 && compressed_o) else $error("illegal not masked");
  end
endmodule

// File: tb/rvc_expander_test.sv
module rvc_expander_test;
  typedef struct packed {
    logic [15:0] h;
    logic [31:0] instr;
    logic        ill;
    logic        cmp;
    logic        vld;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] halfword_i = 16'h0000;
  logic        valid_i = 1'b0;
  logic [31:0] instr_o;
  logic        valid_o, illegal_o, compressed_o;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  exp_t        exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  rvc_expander uut (
    .halfword_i   (halfword_i),
    .valid_i      (valid_i),
    .instr_o      (instr_o),
    .valid_o      (valid_o),
    .illegal_o    (illegal_o),
    .compressed_o (compressed_o)
  );

  function automatic exp_t model(input logic [15:0] h, input logic v, output string tag);
    exp_t e;
    logic bad;
    logic [31:0] w, im;
    logic [4:0] ra, rb, rf, rs;
    logic [2:0] f3;
    ra = 5'd8 + {2'b00, h[9:7]};
    rb = 5'd8 + {2'b00, h[4:2]};
    rf = h[11:7];
    rs = h[6:2];
    bad = 1'b0; w = '0; im = '0; tag = "R11";
    e.h = h; e.vld = v;
    if (h[1:0] == 2'b11) begin
      tag = "R1"; e.instr = {16'h0000, h}; e.ill = 1'b0; e.cmp = 1'b0;
      return e;
    end
    case ({h[1:0], h[15:13]})
      5'b00_000: begin
        tag = "R3";
        im[5] = h[12]; im[4] = h[11]; im[9:6] = h[10:7]; im[2] = h[6]; im[3] = h[5];
        bad = (im == 0);
        w = {im[11:0], 5'd2, 3'b000, rb, 7'h13};
      end
      5'b00_010, 5'b00_110: begin
        tag = "R2";
        im[5:3] = h[12:10]; im[2] = h[6]; im[6] = h[5];
        if (h[15]) w = {im[11:5], rb, ra, 3'b010, im[4:0], 7'h23};
        else       w = {im[11:0], ra, 3'b010, rb, 7'h03};
      end
      5'b01_000, 5'b01_010: begin
        tag = "R13";
        im = {{26{h[12]}}, h[12], h[6:2]};
        w = {im[11:0], (h[14] ? 5'd0 : rf), 3'b000, rf, 7'h13};
      end
      5'b01_001, 5'b01_101: begin
        tag = "R4";
        im[11] = h[12]; im[4] = h[11]; im[9:8] = h[10:9]; im[10] = h[8];
        im[6] = h[7]; im[7] = h[6]; im[3:1] = h[5:3]; im[5] = h[2];
        if (h[12]) im[31:12] = '1;
        w = {im[20], im[10:1], im[11], im[19:12], (h[15] ? 5'd0 : 5'd1), 7'h6f};
      end
      5'b01_011: begin
        tag = "R6";
        if (rf == 5'd2) begin
          im[9] = h[12]; im[4] = h[6]; im[6] = h[5]; im[8:7] = h[4:3]; im[5] = h[2];
          bad = (im == 0);
          if (h[12]) im[31:10] = '1;
          w = {im[11:0], 5'd2, 3'b000, 5'd2, 7'h13};
        end else begin
          im = {{14{h[12]}}, h[12], h[6:2], 12'h000};
          bad = (rf == 0) || ({h[12], h[6:2]} == 0);
          w = {im[31:12], rf, 7'h37};
        end
      end
      5'b01_100: begin
        case (h[11:10])
          2'b00, 2'b01: begin
            tag = "R7"; bad = h[12];
            w = {1'b0, h[10], 5'b00000, h[6:2], ra, 3'b101, ra, 7'h13};
          end
          2'b10: begin
            tag = "R8";
            im = {{26{h[12]}}, h[12], h[6:2]};
            w = {im[11:0], ra, 3'b111, ra, 7'h13};
          end
          default: begin
            tag = "R8"; bad = h[12];
            f3 = (h[6:5] == 2'd0) ? 3'd0 : (h[6:5] == 2'd1) ? 3'd4 : (h[6:5] == 2'd2) ? 3'd6 : 3'd7;
            w = {(h[6:5] == 2'd0) ? 7'h20 : 7'h00, rb, ra, f3, ra, 7'h33};
          end
        endcase
      end
      5'b01_110, 5'b01_111: begin
        tag = "R5";
        im[8] = h[12]; im[4:3] = h[11:10]; im[7:6] = h[6:5]; im[2:1] = h[4:3]; im[5] = h[2];
        if (h[12]) im[31:9] = '1;
        w = {im[12], im[10:5], 5'd0, ra, {2'b00, h[13]}, im[4:1], im[11], 7'h63};
      end
      5'b10_000: begin
        tag = "R7"; bad = h[12];
        w = {7'd0, rs, rf, 3'b001, rf, 7'h13};
      end
      5'b10_010: begin
        tag = "R10"; bad = (rf == 0);
        im[5] = h[12]; im[4:2] = h[6:4]; im[7:6] = h[3:2];
        w = {im[11:0], 5'd2, 3'b010, rf, 7'h03};
      end
      5'b10_100: begin
        tag = "R9";
        if (!h[12]) begin
          if (rs == 0) begin bad = (rf == 0); w = {12'd0, rf, 3'b000, 5'd0, 7'h67}; end
          else w = {7'd0, rs, 5'd0, 3'b000, rf, 7'h33};
        end else if (rs == 0) begin
          if (rf == 0) w = 32'h00100073;
          else         w = {12'd0, rf, 3'b000, 5'd1, 7'h67};
        end else w = {7'd0, rs, rf, 3'b000, rf, 7'h33};
      end
      5'b10_110: begin
        tag = "R10";
        im[5:2] = h[12:9]; im[7:6] = h[8:7];
        w = {im[11:5], rs, 5'd2, 3'b010, im[4:0], 7'h23};
      end
      default: bad = 1'b1;
    endcase
    e.instr = bad ? 32'd0 : w;
    e.ill = v & bad;
    e.cmp = 1'b1;
    return e;
  endfunction

  task automatic drive(input logic [15:0] h, input logic v);
    exp_t e;
    string t;
    @(posedge clk);
    halfword_i = h;
    valid_i = v;
    e = model(h, v, t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic drive_golden(input logic [15:0] h, input logic [31:0] w, input string t);
    exp_t e;
    @(posedge clk);
    halfword_i = h;
    valid_i = 1'b1;
    e.h = h; e.instr = w; e.ill = 1'b0; e.cmp = 1'b1; e.vld = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Monitor: pops one expected item per cycle, samples mid-period
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (instr_o !== e.instr || illegal_o !== e.ill || compressed_o !== e.cmp || valid_o !== e.vld) begin
          n_fail++;
          $display("FAIL %s h=%h got instr=%h ill=%b cmp=%b vld=%b exp instr=%h ill=%b cmp=%b vld=%b",
                   t, e.h, instr_o, illegal_o, compressed_o, valid_o, e.instr, e.ill, e.cmp, e.vld);
        end
      end
    end
  end

  initial begin
    // reset state: qualifier low, nothing flagged (R12)
    drive(16'h0000, 1'b0);
    drive(16'h0000, 1'b0);
    rst = 1'b0;
    // golden words written by hand
    drive_golden(16'h0001, 32'h00000013, "R13");
    drive_golden(16'h4501, 32'h00000513, "R13");
    drive_golden(16'h9002, 32'h00100073, "R9");
    drive_golden(16'h8082, 32'h00008067, "R9");
    // directed corners
    drive(16'h0000, 1'b1);  // R3 all-zero
    drive(16'h1001, 1'b1);  // R7 SRLI-space? quadrant 01 fn 000 with b12: R13
    drive(16'h9001, 1'b1);  // R7 bit 12 shift
    drive(16'h9c01, 1'b1);  // R8 word-form slot
    drive(16'h6101, 1'b1);  // R6 ADDI16SP zero
    drive(16'h6001, 1'b1);  // R6 LUI rd0
    drive(16'h4002, 1'b1);  // R10 LWSP rd0
    drive(16'h2000, 1'b1);  // R11 reserved slot
    drive(16'hffff, 1'b1);  // R1 wide
    // exhaustive sweep
    for (int i = 0; i < 65536; i++) drive(i[15:0], 1'b1);
    // qualifier low on illegal encodings (R12)
    drive(16'h0000, 1'b0);
    drive(16'h2000, 1'b0);
    drive(16'h9001, 1'b0);
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule